// File: doc/BRIEF.md
# Low-Power Mode Clock Gating Controller

This block keeps track of the chip's operating mode and turns it into clock enable levels. Three modes exist: Run, where everything is clocked; Wait, where the core and memory clock is gated off and every peripheral keeps its clock; and Stop, where only the peripherals that software has marked as stay-awake keep their clock. A core asks for Wait or Stop with a one-cycle request pulse, as it would after executing the matching instruction. Wake events take the part back to Run. These events are peripheral interrupts, a low-voltage interrupt and a debug-entry request. An asserted combined reset, whatever its source, also returns the part to Run at once.

The outputs are registered levels meant to drive clock-gate cells elsewhere. The block does no gating itself. It does not generate clocks and it does not control oscillators or regulators. Wait or Stop requests are accepted the same way whatever the clock source speed, so they can be layered on a slow standby clock.

States are `MODE_RUN`, `MODE_WAIT` and `MODE_STOP`. There are five transitions. Run goes to Stop on a stop request with no Stop-qualifying wake. Run goes to Wait on a wait request alone with no wake event. Wait goes to Run on any wake event. Stop goes to Run on a Stop-qualifying wake. Any mode goes to Run on reset.

Top module: `lpm_clk_ctrl`

## Requirements
- R1: While and after reset (`rst_n` low), `mode` is 2'b00 (Run), `core_clk_en` is 1 and every bit of `periph_clk_en` is 1.
- R2: In Run, a `wait_req` pulse without `stop_req` and with no wake event (any `irq` bit, `lv_irq`, `dbg_req`) sets `mode` to 2'b01 (Wait) at the next clock edge.
- R3: While in Wait, `core_clk_en` is 0 and all `periph_clk_en` bits are 1.
- R4: In Wait, any `irq` bit, `lv_irq` or `dbg_req` returns `mode` to Run at the next edge.
- R5: In Run, a `stop_req` pulse with no Stop-qualifying wake sets `mode` to 2'b10 (Stop) at the next edge. Stop takes priority when `wait_req` and `stop_req` arrive together.
- R6: While in Stop, `core_clk_en` is 0 and `periph_clk_en[i]` equals `stop_keep[i]`, sampled one cycle earlier.
- R7: In Stop, only `irq[i]` with `stop_keep[i]` set, `lv_irq` or `dbg_req` returns to Run. An interrupt from a peripheral whose `stop_keep` bit is clear leaves `mode` at Stop.
- R8: A Wait or Stop request in the same cycle as a wake event that qualifies for the requested mode leaves `mode` at Run.
- R9: `wait_req` and `stop_req` are ignored while in Wait or Stop, and `mode` is unchanged.
- R10: Clock enables follow the registered mode one cycle later. In Run, all enables are 1.
- R11: Reset taken from Wait or Stop returns `mode` to Run and raises all enables without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Combined active-low reset (all sources), asynchronous |
| wait_req | input | 1 | One-cycle request to enter Wait |
| stop_req | input | 1 | One-cycle request to enter Stop |
| irq | input | NUM_PERIPH | Interrupt line per peripheral |
| stop_keep | input | NUM_PERIPH | Per-peripheral stay-awake-in-Stop bit |
| lv_irq | input | 1 | Low-voltage interrupt |
| dbg_req | input | 1 | Debug-entry request |
| core_clk_en | output | 1 | Core and memory clock enable |
| periph_clk_en | output | NUM_PERIPH | Per-peripheral clock enable |
| mode | output | 2 | Current mode: 00 Run, 01 Wait, 10 Stop |

## Verification
The bench builds the block with `NUM_PERIPH` = 4. With that width, a stay-awake mask of 0101 leaves kept and unkept peripherals side by side. This lets one run show that an interrupt on lane 1 is masked in Stop while one on lane 2 wakes the part, and that the Stop enable pattern matches the mask bit for bit. Four lanes also let Wait be left by an interrupt on an upper lane, which shows that every bit of the vector counts as a wake source.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [1:0] {
        MODE_RUN  = 2'b00,
        MODE_WAIT = 2'b01,
        MODE_STOP = 2'b10
    } lpm_mode_e;

endpackage

// File: rtl/lpm_wake_qual.sv
module lpm_wake_qual #(
    parameter int NUM_PERIPH = 4
) (
    input  logic [NUM_PERIPH-1:0] irq,
    input  logic [NUM_PERIPH-1:0] stop_keep,
    input  logic                  lv_irq,
    input  logic                  dbg_req,
    output logic                  wake_any,
    output logic                  wake_stop
);

    logic [NUM_PERIPH-1:0] irq_kept;

    // Only interrupts from peripherals that stay clocked in Stop may wake it.
    genvar g;
    generate
        for (g = 0; g < NUM_PERIPH; g++) begin : g_mask
            assign irq_kept[g] = irq[g] & stop_keep[g];
        end
    endgenerate

    always_comb begin
        wake_any  = (|irq) | lv_irq | dbg_req;
        wake_stop = (|irq_kept) | lv_irq | dbg_req;
    end

endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
    import lpm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wait_req,
    input  logic      stop_req,
    input  logic      wake_any,
    input  logic      wake_stop,
    output lpm_mode_e mode_q
);

    lpm_mode_e mode_d;

    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_RUN: begin
                if (stop_req) begin
                    if (!wake_stop) mode_d = MODE_STOP;
                end else if (wait_req) begin
                    if (!wake_any) mode_d = MODE_WAIT;
                end
            end
            MODE_WAIT: begin
                if (wake_any) mode_d = MODE_RUN;
            end
            MODE_STOP: begin
                if (wake_stop) mode_d = MODE_RUN;
            end
            default: mode_d = MODE_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MODE_RUN;
        else        mode_q <= mode_d;
    end

    // R2
    a_r2_wait_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_RUN && wait_req && !stop_req && !wake_any) |=> (mode_q == MODE_WAIT));
    // R4
    a_r4_wait_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_WAIT && wake_any) |=> (mode_q == MODE_RUN));
    // R7
    a_r7_stop_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_STOP && !wake_stop) |=> (mode_q == MODE_STOP));
    // R8
    a_r8_coincide_run: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_RUN && stop_req && wake_stop) |=> (mode_q == MODE_RUN));
    // R9
    a_r9_req_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_WAIT && !wake_any) |=> (mode_q == MODE_WAIT));

endmodule

// File: rtl/lpm_clk_en.sv
module lpm_clk_en
    import lpm_pkg::*;
#(
    parameter int NUM_PERIPH = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  lpm_mode_e             mode_q,
    input  logic [NUM_PERIPH-1:0] stop_keep,
    output logic                  core_clk_en,
    output logic [NUM_PERIPH-1:0] periph_clk_en
);

    localparam logic [NUM_PERIPH-1:0] ALL_ON = {NUM_PERIPH{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_clk_en   <= 1'b1;
            periph_clk_en <= ALL_ON;
        end else begin
            unique case (mode_q)
                MODE_RUN: begin
                    core_clk_en   <= 1'b1;
                    periph_clk_en <= ALL_ON;
                end
                MODE_WAIT: begin
                    core_clk_en   <= 1'b0;
                    periph_clk_en <= ALL_ON;
                end
                MODE_STOP: begin
                    core_clk_en   <= 1'b0;
                    periph_clk_en <= stop_keep;
                end
                default: begin
                    core_clk_en   <= 1'b1;
                    periph_clk_en <= ALL_ON;
                end
            endcase
        end
    end

    // R3
    a_r3_wait_clocks: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_WAIT) |=> (!core_clk_en && periph_clk_en == ALL_ON));
    // R6
    a_r6_stop_clocks: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_STOP) |=> (!core_clk_en && periph_clk_en == $past(stop_keep)));
    // R10
    a_r10_run_clocks: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_RUN) |=> (core_clk_en && periph_clk_en == ALL_ON));

endmodule

// File: rtl/lpm_clk_ctrl.sv
module lpm_clk_ctrl
    import lpm_pkg::*;
#(
    parameter int NUM_PERIPH = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wait_req,
    input  logic                  stop_req,
    input  logic [NUM_PERIPH-1:0] irq,
    input  logic [NUM_PERIPH-1:0] stop_keep,
    input  logic                  lv_irq,
    input  logic                  dbg_req,
    output logic                  core_clk_en,
    output logic [NUM_PERIPH-1:0] periph_clk_en,
    output logic [1:0]            mode
);

    logic      wake_any;
    logic      wake_stop;
    lpm_mode_e mode_q;

    lpm_wake_qual #(.NUM_PERIPH(NUM_PERIPH)) u_wake (
        .irq       (irq),
        .stop_keep (stop_keep),
        .lv_irq    (lv_irq),
        .dbg_req   (dbg_req),
        .wake_any  (wake_any),
        .wake_stop (wake_stop)
    );

    lpm_mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wait_req  (wait_req),
        .stop_req  (stop_req),
        .wake_any  (wake_any),
        .wake_stop (wake_stop),
        .mode_q    (mode_q)
    );

    lpm_clk_en #(.NUM_PERIPH(NUM_PERIPH)) u_en (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_q        (mode_q),
        .stop_keep     (stop_keep),
        .core_clk_en   (core_clk_en),
        .periph_clk_en (periph_clk_en)
    );

    assign mode = mode_q;

    // R5: a simultaneous wait and stop request resolves to Stop
    a_r5_stop_priority: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00 && stop_req && wait_req && !lv_irq && !dbg_req && ((irq & stop_keep) == '0))
        |=> (mode == 2'b10));

endmodule

// File: tb/lpm_clk_ctrl_tb.sv
module lpm_clk_ctrl_tb_top;

    localparam int NP = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wait_req = 1'b0;
    logic          stop_req = 1'b0;
    logic [NP-1:0] irq = '0;
    logic [NP-1:0] stop_keep = '0;
    logic          lv_irq = 1'b0;
    logic          dbg_req = 1'b0;
    logic          core_clk_en;
    logic [NP-1:0] periph_clk_en;
    logic [1:0]    mode;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    lpm_clk_ctrl #(.NUM_PERIPH(NP)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .wait_req      (wait_req),
        .stop_req      (stop_req),
        .irq           (irq),
        .stop_keep     (stop_keep),
        .lv_irq        (lv_irq),
        .dbg_req       (dbg_req),
        .core_clk_en   (core_clk_en),
        .periph_clk_en (periph_clk_en),
        .mode          (mode)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // drive one-cycle pulse at negedge, return at next negedge (edge taken)
    task automatic pulse(input logic w, input logic s, input logic [NP-1:0] i,
                         input logic lv, input logic dbg);
        @(negedge clk);
        wait_req = w; stop_req = s; irq = i; lv_irq = lv; dbg_req = dbg;
        @(negedge clk);
        wait_req = 0; stop_req = 0; irq = '0; lv_irq = 0; dbg_req = 0;
    endtask

    task automatic t_reset();
        check("R1 mode", {6'd0, mode}, 8'h00);
        check("R1 core", {7'd0, core_clk_en}, 8'h01);
        check("R1 periph", {4'd0, periph_clk_en}, 8'h0F);
    endtask

    task automatic t_wait();
        stop_keep = 4'b0000;
        pulse(1, 0, '0, 0, 0);
        check("R2 wait entry", {6'd0, mode}, 8'h01);
        @(negedge clk);
        check("R3 core off", {7'd0, core_clk_en}, 8'h00);
        check("R3 periph on", {4'd0, periph_clk_en}, 8'h0F);
        pulse(0, 1, '0, 0, 0);
        check("R9 stop in wait", {6'd0, mode}, 8'h01);
        pulse(0, 0, 4'b1000, 0, 0);
        check("R4 irq exit", {6'd0, mode}, 8'h00);
        check("R10 lag core", {7'd0, core_clk_en}, 8'h00);
        @(negedge clk);
        check("R10 run core", {7'd0, core_clk_en}, 8'h01);
        pulse(1, 0, '0, 0, 0);
        pulse(0, 0, '0, 1, 0);
        check("R4 lv exit", {6'd0, mode}, 8'h00);
        pulse(1, 0, '0, 0, 0);
        pulse(0, 0, '0, 0, 1);
        check("R4 dbg exit", {6'd0, mode}, 8'h00);
    endtask

    task automatic t_stop();
        stop_keep = 4'b0101;
        pulse(0, 1, '0, 0, 0);
        check("R5 stop entry", {6'd0, mode}, 8'h02);
        @(negedge clk);
        check("R6 core off", {7'd0, core_clk_en}, 8'h00);
        check("R6 periph keep", {4'd0, periph_clk_en}, 8'h05);
        pulse(0, 0, 4'b0010, 0, 0);
        check("R7 masked irq", {6'd0, mode}, 8'h02);
        check("R7 periph held", {4'd0, periph_clk_en}, 8'h05);
        pulse(1, 0, '0, 0, 0);
        check("R9 wait in stop", {6'd0, mode}, 8'h02);
        pulse(0, 0, 4'b0100, 0, 0);
        check("R7 kept irq exit", {6'd0, mode}, 8'h00);
        @(negedge clk);
        check("R10 run periph", {4'd0, periph_clk_en}, 8'h0F);
        pulse(0, 1, '0, 0, 0);
        pulse(0, 0, '0, 1, 0);
        check("R7 lv exit", {6'd0, mode}, 8'h00);
        pulse(0, 1, '0, 0, 0);
        pulse(0, 0, '0, 0, 1);
        check("R7 dbg exit", {6'd0, mode}, 8'h00);
    endtask

    task automatic t_priority();
        stop_keep = 4'b0101;
        pulse(1, 1, '0, 0, 0);
        check("R5 stop priority", {6'd0, mode}, 8'h02);
        pulse(0, 0, '0, 0, 1);
        check("R5 exit", {6'd0, mode}, 8'h00);
    endtask

    task automatic t_coincide();
        stop_keep = 4'b0101;
        pulse(1, 0, 4'b1000, 0, 0);
        check("R8 wait+irq", {6'd0, mode}, 8'h00);
        pulse(0, 1, '0, 1, 0);
        check("R8 stop+lv", {6'd0, mode}, 8'h00);
        pulse(0, 1, 4'b0010, 0, 0);
        check("R8 stop+unkept irq", {6'd0, mode}, 8'h02);
        pulse(0, 0, '0, 0, 1);
    endtask

    task automatic t_reset_any();
        stop_keep = 4'b0000;
        pulse(0, 1, '0, 0, 0);
        @(negedge clk);
        check("R11 in stop", {6'd0, mode}, 8'h02);
        #1 rst_n = 0;
        #1;
        check("R11 mode", {6'd0, mode}, 8'h00);
        check("R11 core", {7'd0, core_clk_en}, 8'h01);
        check("R11 periph", {4'd0, periph_clk_en}, 8'h0F);
        @(negedge clk);
        rst_n = 1;
        pulse(1, 0, '0, 0, 0);
        #1 rst_n = 0;
        #1;
        check("R11 from wait", {6'd0, mode}, 8'h00);
        @(negedge clk);
        rst_n = 1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_wait();
        t_stop();
        t_priority();
        t_coincide();
        t_reset_any();
        repeat (2) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule